// File: doc/BRIEF.md
# Scaled Integer Add/Compare Unit

This block is a registered 64-bit integer arithmetic stage. Each cycle in which `in_valid` is high it samples two 64-bit operands and a 7-bit function code. One clock later it presents the result on `result` with `out_valid` high. The same cycle also carries an overflow flag and an illegal-code flag. Operands come straight from the caller, and any trap raised by the flags is handled elsewhere.

The unit computes several kinds of result:
- additions and subtractions on quadwords (64 bits) and longwords (32 bits);
- variants that scale operand A by 4 or by 8 before the add or subtract;
- variants that flag signed overflow;
- signed and unsigned magnitude compares and an equality compare, each giving 0 or 1;
- a byte-lane compare that gives an 8-bit mask.

Longword results are sign-extended to 64 bits.

The output side is a two-state machine. `ST_IDLE` drives every output to zero. `ST_SHOW` presents one registered result. The state moves from either state to `ST_SHOW` on a cycle with `in_valid` high, and to `ST_IDLE` on a cycle without it. Back-to-back requests therefore give back-to-back results.

Top module: `sac_unit`

## Requirements
- R1: A request accepted while `in_valid` is high produces `out_valid` high exactly one clock later, for one cycle per request. While `out_valid` is low, `result`, `ovf` and `illegal` are all zero.
- R2: Code 0x20 gives A+B and code 0x29 gives A−B, both over the full 64 bits and wrapping modulo 2^64.
- R3: The scaled codes shift A left before combining it with B:
  - 0x02 gives 4A+B and 0x12 gives 8A+B on 32 bits.
  - 0x0b gives 4A−B and 0x1b gives 8A−B on 32 bits.
  - 0x22 gives 4A+B, 0x32 gives 8A+B, 0x2b gives 4A−B and 0x3b gives 8A−B on 64 bits.
- R4: Longword codes (0x00 add, 0x09 sub and the 32-bit scaled and trapping codes) use only bits 31:0 of each operand. Their 32-bit result is sign-extended, so bits 63:32 of `result` equal bit 31.
- R5: Trapping add codes 0x40 (32-bit) and 0x60 (64-bit) raise `ovf` when A and B share a sign bit and the sum's sign bit differs from A's. The sign bit is bit 31 or bit 63. The wrapped sum is still delivered.
- R6: Trapping subtract codes 0x49 (32-bit) and 0x69 (64-bit) raise `ovf` when the sign bits of A and B differ and the difference's sign bit differs from A's. The wrapped difference is still delivered.
- R7: All non-trapping codes leave `ovf` low, even when the arithmetic wraps.
- R8: The compare codes give `result` = 1 when true and 0 otherwise:
  - 0x2d tests A = B.
  - 0x6d tests A ≤ B signed and 0x4d tests A < B signed.
  - 0x3d tests A ≤ B unsigned and 0x1d tests A < B unsigned.
- R9: Code 0x0f sets bit i of `result` (i = 0..7) when byte i of A, bits 8i+7:8i, is unsigned greater than or equal to byte i of B. Bits 63:8 are zero.
- R10: Any code outside the listed set raises `illegal` and gives `result` = 0 with `ovf` low.
- R11: While reset is asserted, `out_valid`, `result`, `ovf` and `illegal` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands and code are sampled when high |
| func | input | 7 | Function code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Registered result |
| ovf | output | 1 | Signed overflow on a trapping code |
| illegal | output | 1 | Function code not recognised |

## Verification
The bench runs every function code with operands chosen near the sign boundaries (0x7fff_ffff, 0x8000_0000 and their 64-bit equivalents). This separates bit-31 overflow from bit-63 overflow, and trapping codes from their non-trapping twins. The compare codes receive pairs with equal magnitudes but opposite signs, which tells signed ordering apart from unsigned ordering. Byte-mask patterns place equal, larger and smaller bytes in different lanes to expose lane-order errors. A long stream of random operands over all codes, including illegal ones and gaps in `in_valid`, checks back-to-back timing and the quiet outputs between results.

// File: rtl/sac_pkg.sv
package sac_pkg;
    localparam int FUNC_W = 7;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_EQ, K_SLE, K_SLT, K_ULE, K_ULT, K_BYTEGE, K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       narrow;   // 32-bit operation with sign extension
        logic [1:0] shamt;    // left shift applied to operand A
        logic       trap;     // overflow is reported
    } op_ctl_t;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } out_state_e;
endpackage

// File: rtl/sac_decode.sv
module sac_decode
    import sac_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output op_ctl_t           ctl
);
    always_comb begin
        ctl = '{kind: K_BAD, narrow: 1'b0, shamt: 2'd0, trap: 1'b0};
        case (func)
            // additions
            7'h00: ctl = '{K_ADD, 1'b1, 2'd0, 1'b0};
            7'h40: ctl = '{K_ADD, 1'b1, 2'd0, 1'b1};
            7'h02: ctl = '{K_ADD, 1'b1, 2'd2, 1'b0};
            7'h12: ctl = '{K_ADD, 1'b1, 2'd3, 1'b0};
            7'h20: ctl = '{K_ADD, 1'b0, 2'd0, 1'b0};
            7'h60: ctl = '{K_ADD, 1'b0, 2'd0, 1'b1};
            7'h22: ctl = '{K_ADD, 1'b0, 2'd2, 1'b0};
            7'h32: ctl = '{K_ADD, 1'b0, 2'd3, 1'b0};
            // subtractions
            7'h09: ctl = '{K_SUB, 1'b1, 2'd0, 1'b0};
            7'h49: ctl = '{K_SUB, 1'b1, 2'd0, 1'b1};
            7'h0b: ctl = '{K_SUB, 1'b1, 2'd2, 1'b0};
            7'h1b: ctl = '{K_SUB, 1'b1, 2'd3, 1'b0};
            7'h29: ctl = '{K_SUB, 1'b0, 2'd0, 1'b0};
            7'h69: ctl = '{K_SUB, 1'b0, 2'd0, 1'b1};
            7'h2b: ctl = '{K_SUB, 1'b0, 2'd2, 1'b0};
            7'h3b: ctl = '{K_SUB, 1'b0, 2'd3, 1'b0};
            // compares
            7'h2d: ctl.kind = K_EQ;
            7'h6d: ctl.kind = K_SLE;
            7'h4d: ctl.kind = K_SLT;
            7'h3d: ctl.kind = K_ULE;
            7'h1d: ctl.kind = K_ULT;
            7'h0f: ctl.kind = K_BYTEGE;
            default: ctl.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/sac_arith.sv
module sac_arith
    import sac_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  op_ctl_t           ctl,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_sc;
    logic [DATA_W-1:0] raw;
    logic              is_sub;
    logic              sgn_a, sgn_b, sgn_r;

    assign is_sub = (ctl.kind == K_SUB);
    assign a_sc   = a << ctl.shamt;
    assign raw    = is_sub ? (a_sc - b) : (a_sc + b);

    always_comb begin
        if (ctl.narrow) begin
            res   = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            sgn_a = a_sc[HALF_W-1];
            sgn_b = b[HALF_W-1];
            sgn_r = raw[HALF_W-1];
        end else begin
            res   = raw;
            sgn_a = a_sc[DATA_W-1];
            sgn_b = b[DATA_W-1];
            sgn_r = raw[DATA_W-1];
        end
        // subtraction overflows only when operand signs differ
        ovf = ctl.trap && (is_sub ? (sgn_a != sgn_b) : (sgn_a == sgn_b))
                       && (sgn_r != sgn_a);
    end
endmodule

// File: rtl/sac_compare.sv
module sac_compare
    import sac_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  op_kind_e          kind,
    output logic [DATA_W-1:0] res
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_ge;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ge[g] = (a[g*LANE_W +: LANE_W] >= b[g*LANE_W +: LANE_W]);
    end

    always_comb begin
        res = '0;
        unique case (kind)
            K_EQ:    res[0] = (a == b);
            K_SLE:   res[0] = ($signed(a) <= $signed(b));
            K_SLT:   res[0] = ($signed(a) <  $signed(b));
            K_ULE:   res[0] = (a <= b);
            K_ULT:   res[0] = (a <  b);
            K_BYTEGE: res[LANES-1:0] = lane_ge;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/sac_unit.sv
module sac_unit
    import sac_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [6:0]        func,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ovf,
    output logic              illegal
);
    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = DATA_W / LANE_W;

    op_ctl_t           ctl;
    logic [DATA_W-1:0] ar_res, cmp_res, nxt_res;
    logic              ar_ovf, nxt_ovf, nxt_ill;
    out_state_e        state, state_nxt;

    sac_decode u_dec (.func(func), .ctl(ctl));

    sac_arith #(.DATA_W(DATA_W)) u_arith (
        .a(opa), .b(opb), .ctl(ctl), .res(ar_res), .ovf(ar_ovf)
    );

    sac_compare #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
        .a(opa), .b(opb), .kind(ctl.kind), .res(cmp_res)
    );

    always_comb begin
        nxt_res = '0;
        nxt_ovf = 1'b0;
        nxt_ill = 1'b0;
        unique case (ctl.kind)
            K_ADD, K_SUB: begin
                nxt_res = ar_res;
                nxt_ovf = ar_ovf;
            end
            K_BAD:   nxt_ill = 1'b1;
            default: nxt_res = cmp_res;
        endcase
    end

    // next state: ST_IDLE/ST_SHOW -> ST_SHOW on a request, else -> ST_IDLE
    always_comb state_nxt = in_valid ? ST_SHOW : ST_IDLE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            ovf     <= 1'b0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            result  <= nxt_res;
            ovf     <= nxt_ovf;
            illegal <= nxt_ill;
        end else begin
            result  <= '0;
            ovf     <= 1'b0;
            illegal <= 1'b0;
        end
    end

    assign out_valid = (state == ST_SHOW);

    // ---------------- assertions ----------------
    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (result == '0 && !ovf && !illegal));
    a_r10_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0 && !ovf));
    a_r7_no_trap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctl.trap) |=> !ovf);
    a_r4_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl.narrow && (ctl.kind == K_ADD || ctl.kind == K_SUB)) |=>
        ($countones(result[DATA_W-1:HALF_W-1]) == 0 ||
         $countones(result[DATA_W-1:HALF_W-1]) == HALF_W + 1));
    a_r8_cmp_bool: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (func == 7'h2d || func == 7'h6d || func == 7'h4d ||
                      func == 7'h3d || func == 7'h1d)) |=> (result[DATA_W-1:1] == '0));
    a_r9_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func == 7'h0f) |=> (result[DATA_W-1:LANES] == '0));
endmodule

// File: tb/test_sac_unit.sv
module test_sac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  func = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid, ovf, illegal;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;

    logic [63:0] q_res[$];
    logic        q_ovf[$];
    logic        q_ill[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    sac_unit i_sac_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
        .ovf(ovf), .illegal(illegal)
    );

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // reference model written from the requirements
    function automatic void model(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] r, output logic v, output logic il,
                                  output string tag);
        logic [31:0] al, bl, t;
        logic [32:0] n33;
        logic [64:0] w65;
        al = a[31:0]; bl = b[31:0];
        r = '0; v = 1'b0; il = 1'b0; tag = "R2";
        case (f)
            7'h00: begin t = al + bl; r = sx(t); tag = "R4"; end
            7'h09: begin t = al - bl; r = sx(t); tag = "R4"; end
            7'h40: begin n33 = {al[31], al} + {bl[31], bl}; r = sx(n33[31:0]);
                         v = n33[32] ^ n33[31]; tag = "R5"; end
            7'h49: begin n33 = {al[31], al} - {bl[31], bl}; r = sx(n33[31:0]);
                         v = n33[32] ^ n33[31]; tag = "R6"; end
            7'h02: begin t = al * 4 + bl; r = sx(t); tag = "R3"; end
            7'h12: begin t = al * 8 + bl; r = sx(t); tag = "R3"; end
            7'h0b: begin t = al * 4 - bl; r = sx(t); tag = "R3"; end
            7'h1b: begin t = al * 8 - bl; r = sx(t); tag = "R3"; end
            7'h20: r = a + b;
            7'h29: r = a - b;
            7'h60: begin w65 = {a[63], a} + {b[63], b}; r = w65[63:0];
                         v = w65[64] ^ w65[63]; tag = "R5"; end
            7'h69: begin w65 = {a[63], a} - {b[63], b}; r = w65[63:0];
                         v = w65[64] ^ w65[63]; tag = "R6"; end
            7'h22: begin r = a * 4 + b; tag = "R3"; end
            7'h32: begin r = a * 8 + b; tag = "R3"; end
            7'h2b: begin r = a * 4 - b; tag = "R3"; end
            7'h3b: begin r = a * 8 - b; tag = "R3"; end
            7'h2d: begin r = {63'd0, a == b}; tag = "R8"; end
            7'h6d: begin r = {63'd0, $signed(a) <= $signed(b)}; tag = "R8"; end
            7'h4d: begin r = {63'd0, $signed(a) <  $signed(b)}; tag = "R8"; end
            7'h3d: begin r = {63'd0, a <= b}; tag = "R8"; end
            7'h1d: begin r = {63'd0, a <  b}; tag = "R8"; end
            7'h0f: begin
                for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
                tag = "R9";
            end
            default: begin il = 1'b1; tag = "R10"; end
        endcase
    endfunction

    task automatic drive(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                         input string tag_ovr);
        logic [63:0] r;
        logic        v, il;
        string       tag;
        model(f, a, b, r, v, il, tag);
        if (tag_ovr != "") tag = tag_ovr;
        @(negedge clk);
        in_valid = 1'b1; func = f; opa = a; opb = b;
        q_res.push_back(r); q_ovf.push_back(v); q_ill.push_back(il); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (out_valid) begin
                    checks++;
                    if (q_res.size() == 0) begin
                        fails++;
                        $display("FAIL R1: out_valid=1 with no pending request (act res=%h exp none)", result);
                    end else begin
                        logic [63:0] er;
                        logic ev, ei;
                        string et;
                        er = q_res.pop_front(); ev = q_ovf.pop_front();
                        ei = q_ill.pop_front(); et = q_tag.pop_front();
                        if (result !== er || ovf !== ev || illegal !== ei) begin
                            fails++;
                            $display("FAIL %s: act res=%h ovf=%b ill=%b exp res=%h ovf=%b ill=%b",
                                     et, result, ovf, illegal, er, ev, ei);
                        end
                    end
                end else begin
                    checks++;
                    if (result !== '0 || ovf !== 1'b0 || illegal !== 1'b0 || q_res.size() != 0) begin
                        fails++;
                        $display("FAIL R1: idle act res=%h ovf=%b ill=%b pending=%0d exp zeros, 0 pending",
                                 result, ovf, illegal, q_res.size());
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: act running exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [6:0] CODES [26] = '{
        7'h00, 7'h40, 7'h02, 7'h12, 7'h20, 7'h60, 7'h22, 7'h32,
        7'h09, 7'h49, 7'h0b, 7'h1b, 7'h29, 7'h69, 7'h2b, 7'h3b,
        7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d, 7'h0f, 7'h7f, 7'h01, 7'h10, 7'h2e
    };

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || ovf !== 1'b0 || illegal !== 1'b0) begin
            fails++;
            $display("FAIL R11: act vld=%b res=%h ovf=%b ill=%b exp all zero",
                     out_valid, result, ovf, illegal);
        end
        rst_n = 1'b1;
        idle(2);

        // R2 wrap
        drive(7'h20, 64'hffff_ffff_ffff_ffff, 64'd2, "R2");
        drive(7'h29, 64'd1, 64'd3, "R2");
        // R3 scaled
        drive(7'h02, 64'h1234_5678_0000_0003, 64'd5, "R3");
        drive(7'h12, 64'h0000_0000_1000_0001, 64'd1, "R3");
        drive(7'h1b, 64'd2, 64'd100, "R3");
        drive(7'h32, 64'h2000_0000_0000_0001, 64'd7, "R3");
        drive(7'h2b, 64'd3, 64'd20, "R3");
        // R4 sign extension and upper bits ignored
        drive(7'h00, 64'hdead_beef_7fff_fff0, 64'hffff_0000_0000_0020, "R4");
        drive(7'h09, 64'h0000_0001_0000_0000, 64'd1, "R4");
        // R5 / R6 overflow boundaries
        drive(7'h40, 64'h0000_0000_7fff_ffff, 64'd1, "R5");
        drive(7'h40, 64'h0000_0000_8000_0000, 64'hffff_ffff_ffff_ffff, "R5");
        drive(7'h60, 64'h7fff_ffff_ffff_ffff, 64'd1, "R5");
        drive(7'h60, 64'h7fff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, "R5");
        drive(7'h49, 64'h0000_0000_8000_0000, 64'd1, "R6");
        drive(7'h49, 64'h0000_0000_8000_0000, 64'hffff_ffff_ffff_ffff, "R6");
        drive(7'h69, 64'h8000_0000_0000_0000, 64'd1, "R6");
        drive(7'h69, 64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, "R6");
        // R7 non-trapping twins on the same operands
        drive(7'h00, 64'h0000_0000_7fff_ffff, 64'd1, "R7");
        drive(7'h20, 64'h7fff_ffff_ffff_ffff, 64'd1, "R7");
        drive(7'h29, 64'h8000_0000_0000_0000, 64'd1, "R7");
        idle(3);
        // R8 compares, signed vs unsigned
        drive(7'h2d, 64'h55, 64'h55, "R8");
        drive(7'h4d, 64'hffff_ffff_ffff_ffff, 64'd1, "R8");
        drive(7'h1d, 64'hffff_ffff_ffff_ffff, 64'd1, "R8");
        drive(7'h6d, 64'd9, 64'd9, "R8");
        drive(7'h3d, 64'd10, 64'd9, "R8");
        // R9 byte mask
        drive(7'h0f, 64'h00ff_7f80_0102_0304, 64'h00fe_8080_0203_0303, "R9");
        drive(7'h0f, 64'h0, 64'hffff_ffff_ffff_ffff, "R9");
        // R10 illegal codes
        drive(7'h7f, 64'h1, 64'h2, "R10");
        drive(7'h01, 64'hffff, 64'h1, "R10");
        idle(2);

        // random stream with gaps (R1 timing)
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom_range(0, 25);
            drive(CODES[k], {$urandom, $urandom}, {$urandom, $urandom}, "");
            if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
        end
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule